// File: doc/BRIEF.md
# Posted-Access Match Timer

This peripheral keeps a free-running 32-bit up counter in a slow timer clock domain and raises a level interrupt when that counter steps onto a programmed compare value. Software reaches it through a plain 32-bit register port clocked by the system clock. Nothing that touches the counter or the compare value is applied at once. A write to the compare or counter register is posted into the timer domain. To read the counter, software first asks for a snapshot through the control register and then reads a latch.

Each of the three crossings has its own busy flag in an access register that software polls. Every crossing runs through a two-state handshake engine, `mt_xfer`, with the states `XF_IDLE` and `XF_WAIT`. Transition *launch* (`XF_IDLE` to `XF_WAIT`) happens when an accepted request toggles the request line and captures the payload. Transition *complete* (`XF_WAIT` to `XF_IDLE`) happens when the synchronised acknowledge toggle equals the request toggle. A request that arrives while its engine is in `XF_WAIT` is dropped. Compare events travel back to the bus domain as a toggle and set a sticky flag there.

Top module: `mt_match_timer`

## Requirements
- R1: After reset, offset 0x00 (compare) reads 0xFFFFFFFF. Offsets 0x10 (counter latch), 0x14 (flags), 0x1C (enable mask), 0x20 (control) and 0x24 (access) all read 0.
- R2: While control bit 0 is 1, the counter advances by one on each timer clock and wraps from 0xFFFFFFFF to 0. While control bit 0 is 0, it holds its value.
- R3: Writing control with bit 1 set starts a snapshot. Access bit 5 reads 1 until the latch is filled. Offset 0x10 then returns the counter value captured in the timer domain. Control bit 1 always reads 0.
- R4: A write to offset 0x10 is posted. Access bit 4 reads 1 until the value has been loaded into the counter, and counting continues from the loaded value.
- R5: A write to offset 0x00 is posted. Access bit 0 reads 1 until the timer domain holds the value. Offset 0x00 reads back the last accepted value.
- R6: A compare, counter or snapshot request that arrives while its own access bit is 1 is ignored.
- R7: When the counter advances onto the compare value, flag bit 0 at offset 0x14 becomes 1 and stays 1.
- R8: Writing to offset 0x14 clears each flag whose data bit is 1 and leaves the other flags unchanged.
- R9: The irq output is high exactly when some flag bit in 3:0 and the matching bit of the enable mask at 0x1C are both 1. Bit 0 of the mask gates the compare flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (register port) clock |
| rst_n | input | 1 | Active-low asynchronous reset, system domain |
| tclk | input | 1 | Timer clock |
| trst_n | input | 1 | Active-low asynchronous reset, timer domain |
| wen | input | 1 | Register write strobe |
| addr | input | 6 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
On every cycle, the embedded properties check several things. The counter steps by exactly one or holds, depending on the synchronised enable. A handshake payload never changes while its engine is in `XF_WAIT`. A compare write made while the compare engine is busy leaves the readback unchanged. Flags are only cleared by a write to the flag register, and irq never rises with an empty mask.

Other behaviour can only be shown by the bench scenarios, because it depends on values that cross domains and travel end to end through both engines. These cover the exact values returned by snapshots, the wrap of the counter, the loaded counter value surviving a rejected second write, and the compare flag appearing only once the count reaches the compare value.

// File: rtl/mt_pkg.sv
`timescale 1ns/1ps
package mt_pkg;
    localparam int ADDR_W  = 6;
    localparam int DATA_W  = 32;
    localparam int NFLAG   = 4;

    localparam logic [ADDR_W-1:0] OFS_MATCH = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_COUNT = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_FLAGS = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_MASK  = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_ACC   = 6'h24;

    localparam int ACC_SNAP_BIT  = 5;
    localparam int ACC_COUNT_BIT = 4;
    localparam int ACC_MATCH_BIT = 0;

    typedef enum logic {XF_IDLE, XF_WAIT} xf_state_e;
endpackage

// File: rtl/mt_sync.sv
`timescale 1ns/1ps
module mt_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/mt_xfer.sv
`timescale 1ns/1ps
module mt_xfer
    import mt_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         src_clk,
    input  logic         src_rst_n,
    input  logic         src_go,
    input  logic [W-1:0] src_data,
    output logic         src_busy,
    output logic         src_done,
    input  logic         dst_clk,
    input  logic         dst_rst_n,
    output logic         dst_pulse,
    output logic [W-1:0] dst_data
);
    xf_state_e    state, state_nx;
    logic         req_t;
    logic [W-1:0] hold;
    logic         ack_s;
    logic         dst_req_s;
    logic         dst_seen;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            XF_IDLE: if (src_go) state_nx = XF_WAIT;
            XF_WAIT: if (ack_s == req_t) state_nx = XF_IDLE;
            default: state_nx = XF_IDLE;
        endcase
    end

    always_ff @(posedge src_clk or negedge src_rst_n) begin
        if (!src_rst_n) state <= XF_IDLE;
        else            state <= state_nx;
    end

    always_ff @(posedge src_clk or negedge src_rst_n) begin
        if (!src_rst_n) begin
            req_t <= 1'b0;
            hold  <= '0;
        end else if (state == XF_IDLE && src_go) begin
            req_t <= ~req_t;
            hold  <= src_data;
        end
    end

    // outputs
    always_comb begin
        src_busy = (state == XF_WAIT);
        src_done = (state == XF_WAIT) && (ack_s == req_t);
    end

    mt_sync #(.W(1), .STAGES(2)) u_req_sync (
        .clk(dst_clk), .rst_n(dst_rst_n), .d(req_t), .q(dst_req_s)
    );

    always_ff @(posedge dst_clk or negedge dst_rst_n) begin
        if (!dst_rst_n) dst_seen <= 1'b0;
        else            dst_seen <= dst_req_s;
    end

    assign dst_pulse = dst_req_s ^ dst_seen;
    assign dst_data  = hold;

    mt_sync #(.W(1), .STAGES(2)) u_ack_sync (
        .clk(src_clk), .rst_n(src_rst_n), .d(dst_seen), .q(ack_s)
    );

    // R6
    hold_while_busy_chk: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        src_busy |=> $stable(hold));
    // R4
    busy_needs_go_chk: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        $rose(src_busy) |-> $past(src_go));
endmodule

// File: rtl/mt_match_timer.sv
`timescale 1ns/1ps
module mt_match_timer
    import mt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tclk,
    input  logic        trst_n,
    input  logic        wen,
    input  logic [5:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        irq
);
    // ---------------- bus domain ----------------
    logic              wr_match, wr_count, wr_flags, wr_mask, wr_ctrl;
    logic              match_go, count_go, snap_go;
    logic              match_busy, count_busy, snap_busy;
    logic              match_done, count_done, snap_done;
    logic [DATA_W-1:0] match_shadow;
    logic [DATA_W-1:0] snap_latch;
    logic [NFLAG-1:0]  flags, mask;
    logic              ctrl_en;
    logic              ev_s, ev_d, match_set;

    // ---------------- timer domain ----------------
    logic              en_t;
    logic [DATA_W-1:0] cnt, cnt_inc, match_t, snap_t;
    logic              m_pulse, c_pulse, s_pulse;
    logic [DATA_W-1:0] m_data, c_data;
    logic              s_data;
    logic              ev_t;

    assign wr_match = wen && (addr == OFS_MATCH);
    assign wr_count = wen && (addr == OFS_COUNT);
    assign wr_flags = wen && (addr == OFS_FLAGS);
    assign wr_mask  = wen && (addr == OFS_MASK);
    assign wr_ctrl  = wen && (addr == OFS_CTRL);

    assign match_go = wr_match && !match_busy;
    assign count_go = wr_count && !count_busy;
    assign snap_go  = wr_ctrl && wdata[1] && !snap_busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_shadow <= '1;
            ctrl_en      <= 1'b0;
            mask         <= '0;
        end else begin
            if (match_go) match_shadow <= wdata;
            if (wr_ctrl)  ctrl_en      <= wdata[0];
            if (wr_mask)  mask         <= wdata[NFLAG-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         snap_latch <= '0;
        else if (snap_done) snap_latch <= snap_t;
    end

    mt_sync #(.W(1), .STAGES(2)) u_ev_sync (
        .clk(clk), .rst_n(rst_n), .d(ev_t), .q(ev_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ev_d <= 1'b0;
        else        ev_d <= ev_s;
    end

    assign match_set = ev_s ^ ev_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else flags <= (flags & ~(wr_flags ? wdata[NFLAG-1:0] : {NFLAG{1'b0}}))
                    | {{(NFLAG-1){1'b0}}, match_set};
    end

    assign irq = |(flags & mask);

    always_comb begin
        rdata = '0;
        unique case (addr)
            OFS_MATCH: rdata = match_shadow;
            OFS_COUNT: rdata = snap_latch;
            OFS_FLAGS: rdata[NFLAG-1:0] = flags;
            OFS_MASK:  rdata[NFLAG-1:0] = mask;
            OFS_CTRL:  rdata[0] = ctrl_en;
            OFS_ACC: begin
                rdata[ACC_SNAP_BIT]  = snap_busy;
                rdata[ACC_COUNT_BIT] = count_busy;
                rdata[ACC_MATCH_BIT] = match_busy;
            end
            default: rdata = '0;
        endcase
    end

    // ---------------- crossings ----------------
    mt_xfer #(.W(DATA_W)) u_match_xf (
        .src_clk(clk), .src_rst_n(rst_n), .src_go(match_go), .src_data(wdata),
        .src_busy(match_busy), .src_done(match_done),
        .dst_clk(tclk), .dst_rst_n(trst_n), .dst_pulse(m_pulse), .dst_data(m_data)
    );

    mt_xfer #(.W(DATA_W)) u_count_xf (
        .src_clk(clk), .src_rst_n(rst_n), .src_go(count_go), .src_data(wdata),
        .src_busy(count_busy), .src_done(count_done),
        .dst_clk(tclk), .dst_rst_n(trst_n), .dst_pulse(c_pulse), .dst_data(c_data)
    );

    mt_xfer #(.W(1)) u_snap_xf (
        .src_clk(clk), .src_rst_n(rst_n), .src_go(snap_go), .src_data(1'b1),
        .src_busy(snap_busy), .src_done(snap_done),
        .dst_clk(tclk), .dst_rst_n(trst_n), .dst_pulse(s_pulse), .dst_data(s_data)
    );

    mt_sync #(.W(1), .STAGES(2)) u_en_sync (
        .clk(tclk), .rst_n(trst_n), .d(ctrl_en), .q(en_t)
    );

    // ---------------- timer domain ----------------
    assign cnt_inc = cnt + 1'b1;

    always_ff @(posedge tclk or negedge trst_n) begin
        if (!trst_n) begin
            cnt     <= '0;
            match_t <= '1;
            snap_t  <= '0;
            ev_t    <= 1'b0;
        end else begin
            if (c_pulse)   cnt <= c_data;
            else if (en_t) cnt <= cnt_inc;
            if (m_pulse)   match_t <= m_data;
            if (s_pulse && s_data) snap_t <= cnt;
            if (!c_pulse && en_t && (cnt_inc == match_t)) ev_t <= ~ev_t;
        end
    end

    // R2
    cnt_step_chk: assert property (@(posedge tclk) disable iff (!trst_n)
        (en_t && !c_pulse) |=> (cnt == $past(cnt) + 1'b1));
    // R2
    cnt_hold_chk: assert property (@(posedge tclk) disable iff (!trst_n)
        (!en_t && !c_pulse) |=> $stable(cnt));
    // R6
    match_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_match && match_busy) |=> $stable(match_shadow));
    // R8
    flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_flags |=> ((flags & $past(flags)) == $past(flags)));
    // R9
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask != '0));
    // R7
    flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[0]) |-> $past(match_set));
endmodule

// File: tb/mt_match_timer_bench.sv
`timescale 1ns/1ps
module mt_match_timer_bench;
    logic        clk = 1'b0;
    logic        tclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trst_n = 1'b0;
    logic        wen = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // behavioural model of the software-visible state
    logic [31:0] m_match = 32'hFFFF_FFFF;
    logic [3:0]  m_mask = 4'h0;
    logic        m_en = 1'b0;

    always #4  clk  = ~clk;
    always #12 tclk = ~tclk;

    mt_match_timer u_mt_match_timer (
        .clk(clk), .rst_n(rst_n), .tclk(tclk), .trst_n(trst_n),
        .wen(wen), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wen = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wen = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic poll(input logic [31:0] bitmask);
        logic [31:0] v;
        for (int i = 0; i < 300; i++) begin
            rd(6'h24, v);
            if ((v & bitmask) == 0) return;
        end
        chk(1'b0, "R6 poll timeout", v, 32'h0);
    endtask

    task automatic snap(output logic [31:0] v);
        wr(6'h20, {30'd0, 1'b1, m_en});
        poll(32'h20);
        rd(6'h10, v);
    endtask

    task automatic load_count(input logic [31:0] d);
        wr(6'h10, d);
        poll(32'h10);
    endtask

    // per-clock comparison against the model: no irq with an empty model mask
    always @(negedge clk) begin
        if (rst_n && !done && m_mask == 4'h0) begin
            vectors++;
            if (irq !== 1'b0) begin
                miscompares++;
                $display("FAIL R9 irq with empty mask actual=%0b expected=0", irq);
            end
        end
    end

    initial begin
        #1_000_000;
        miscompares++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [31:0] v, v2;
        #100;
        rst_n = 1'b1; trst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset state
        rd(6'h00, v); chk(v == 32'hFFFF_FFFF, "R1 match reset", v, 32'hFFFF_FFFF);
        rd(6'h10, v); chk(v == 0, "R1 count latch reset", v, 0);
        rd(6'h14, v); chk(v == 0, "R1 flags reset", v, 0);
        rd(6'h1C, v); chk(v == 0, "R1 mask reset", v, 0);
        rd(6'h20, v); chk(v == 0, "R1 ctrl reset", v, 0);
        rd(6'h24, v); chk(v == 0, "R1 access reset", v, 0);

        // R4 posted counter write, R3 snapshot
        wr(6'h10, 32'h0000_1234);
        rd(6'h24, v); chk(v[4] == 1'b1, "R4 count busy", v, 32'h10);
        poll(32'h10);
        wr(6'h20, 32'h2);
        rd(6'h24, v); chk(v[5] == 1'b1, "R3 snapshot busy", v, 32'h20);
        poll(32'h20);
        rd(6'h10, v); chk(v == 32'h1234, "R3 R4 snapshot value", v, 32'h1234);
        rd(6'h20, v); chk(v == 0, "R3 ctrl bit1 reads 0", v, 0);

        // R6 second writes while busy are dropped
        wr(6'h10, 32'h500);
        wr(6'h10, 32'h900);
        poll(32'h10);
        snap(v); chk(v == 32'h500, "R6 count write ignored", v, 32'h500);
        wr(6'h00, 32'h7000);
        rd(6'h24, v); chk(v[0] == 1'b1, "R5 match busy", v, 32'h1);
        wr(6'h00, 32'h8000);
        poll(32'h1);
        m_match = 32'h7000;
        rd(6'h00, v); chk(v == m_match, "R5 R6 match readback", v, m_match);

        // R2 hold while disabled
        repeat (20) @(posedge tclk);
        snap(v); chk(v == 32'h500, "R2 hold while disabled", v, 32'h500);

        // R2 counting
        m_en = 1'b1; wr(6'h20, 32'h1);
        repeat (50) @(posedge tclk);
        m_en = 1'b0; wr(6'h20, 32'h0);
        repeat (10) @(posedge tclk);
        snap(v);
        chk((v - 32'h500) >= 46 && (v - 32'h500) <= 54, "R2 count advance", v, 32'h500 + 50);
        repeat (10) @(posedge tclk);
        snap(v2); chk(v2 == v, "R2 stable after disable", v2, v);

        // R2 wrap
        load_count(32'hFFFF_FFF0);
        m_en = 1'b1; wr(6'h20, 32'h1);
        repeat (40) @(posedge tclk);
        m_en = 1'b0; wr(6'h20, 32'h0);
        repeat (10) @(posedge tclk);
        snap(v); chk(v >= 32'h14 && v <= 32'h1C, "R2 wrap", v, 32'h18);

        // R7 R8 R9 compare
        load_count(32'd100);
        wr(6'h00, 32'd130); poll(32'h1); m_match = 32'd130;
        wr(6'h14, 32'hF);
        rd(6'h14, v); chk(v == 0, "R8 flags cleared", v, 0);
        m_en = 1'b1; wr(6'h20, 32'h1);
        repeat (15) @(posedge tclk);
        rd(6'h14, v); chk(v == 0, "R7 no flag before compare", v, 0);
        repeat (40) @(posedge tclk);
        m_en = 1'b0; wr(6'h20, 32'h0);
        repeat (6) @(posedge tclk);
        rd(6'h14, v); chk(v == 1, "R7 flag set at compare", v, 1);
        chk(irq == 1'b0, "R9 irq masked", {31'd0, irq}, 0);
        wr(6'h14, 32'h0);
        rd(6'h14, v); chk(v == 1, "R8 write of zero keeps flag", v, 1);
        wr(6'h14, 32'hE);
        rd(6'h14, v); chk(v == 1, "R8 other bits do not clear bit0", v, 1);
        m_mask = 4'h1; wr(6'h1C, 32'h1);
        rd(6'h1C, v); chk(v == 1, "R9 mask readback", v, 1);
        chk(irq == 1'b1, "R9 irq asserted", {31'd0, irq}, 1);
        wr(6'h14, 32'h1);
        rd(6'h14, v); chk(v == 0, "R8 flag cleared", v, 0);
        chk(irq == 1'b0, "R9 irq released", {31'd0, irq}, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule